// File: doc/BRIEF.md
# Programmable Raster Sync Generator

This block produces the line and frame timing for a video raster. A pixel-tick enable runs either on every clock, for VGA-style output, or on every second clock, for NTSC/PAL output. The block counts pixel ticks into lines and lines into frames, using a programmable horizontal total and a programmable vertical total. It keeps the number of the current scanline and drives a vertical blanking flag. The flag turns on and off at programmable lines.

Three one-cycle pulses mark raster events. Two pulses fire when the scanline reaches either of two programmable lines, and the third marks the start of each frame. A live status word carries the scanline, the blanking flag and an interlace field bit.

In interlaced mode, each line takes half the progressive pixel-tick count, and the field bit flips at every frame start. All timing configuration is captured into shadow registers at reset and again at each wrap to line 0. Values written in the middle of a frame therefore never shorten the line or frame in progress.

Top module: `raster_sync_gen`

## Requirements
- R1: A line lasts ceil((H+1)/S) pixel ticks. H is the horizontal total. S is 2 when interlace is in force and 1 otherwise.
- R2: With `cfg_full_rate`=1 there is a pixel tick on every clock. With `cfg_full_rate`=0 there is a pixel tick on every second clock. A line of L ticks therefore spans L clocks in the first case and 2L clocks in the second.
- R3: The scanline `status[VW-1:0]` advances by one at the end of each line. After line V, the vertical total, it returns to 0. No other change is possible.
- R4: `scan_irq1` is high for exactly the one clock in which the new scanline first appears, and only when that scanline equals `cfg_irq1_line`.
- R5: `scan_irq2` behaves the same way for `cfg_irq2_line`.
- R6: The blanking flag `status[VW]` becomes 1 when the new scanline equals `cfg_blank_on`. It becomes 0 when the new scanline equals `cfg_blank_off`. When both lines are equal, setting wins. The flag changes only when the scanline changes.
- R7: The field bit `status[VW+1]` is 0 throughout any frame in which interlace is not in force.
- R8: In interlaced frames the field bit inverts once per frame, on the wrap to line 0.
- R9: `frame_start` pulses for one clock exactly when the scanline becomes 0.
- R10: Configuration is captured at reset and at every wrap to line 0. The captured set governs every line length and event up to and including the wrap that ends the frame. The new interlace setting decides the field bit at that wrap.
- R11: A synchronous active-high `rst` clears the status word to 0 and holds all pulses low. No pulse appears until the first line completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_htotal | input | HW | Horizontal total H (line = H+1 pixel positions) |
| cfg_vtotal | input | VW | Vertical total V (frame = V+1 lines) |
| cfg_full_rate | input | 1 | 1 = tick every clock, 0 = tick every second clock |
| cfg_interlace | input | 1 | Interlaced timing enable |
| cfg_irq1_line | input | VW | Match line for scan_irq1 |
| cfg_irq2_line | input | VW | Match line for scan_irq2 |
| cfg_blank_on | input | VW | Line at which blanking begins |
| cfg_blank_off | input | VW | Line at which blanking ends |
| status | output | VW+2 | {field, blank, scanline} |
| scan_irq1 | output | 1 | First scanline-match pulse |
| scan_irq2 | output | 1 | Second scanline-match pulse |
| frame_start | output | 1 | Pulse when the scanline becomes 0 |

## Verification
The counters are swept over several small configurations that combine full and half pixel rate with progressive and interlaced timing. Odd and even horizontal totals separate the halving in interlaced lines from a plain halving of the pixel rate. Match and blanking lines placed at 0, at the last line and in the middle of the frame expose off-by-one errors in the wrap and the compare. Equal on and off blanking lines show which of the two has priority. A mid-frame rewrite of every timing input shows whether the shadow capture waits for the frame boundary.

// File: rtl/rsg_pkg.sv
package rsg_pkg;
   typedef enum logic {
      RATE_HALF = 1'b0,
      RATE_FULL = 1'b1
   } rate_e;

   function automatic int unsigned ticks_per_line(input int unsigned htot, input bit ilace);
      int unsigned s;
      s = ilace ? 2 : 1;
      return (htot + s) / s;
   endfunction
endpackage

// File: rtl/rsg_pix_tick.sv
module rsg_pix_tick #(
   parameter int unsigned DIV = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic full_rate,
   input  logic restart,
   output logic tick
);
   localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   logic [CW-1:0] phase;

   generate
      if (DIV < 2) begin : g_bad_div
         $error("rsg_pix_tick: DIV must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || restart)    phase <= '0;
      else if (phase == LAST) phase <= '0;
      else                   phase <= phase + 1'b1;
   end

   assign tick = (full_rate == rsg_pkg::RATE_FULL) || (phase == LAST);
endmodule

// File: rtl/rsg_line_timer.sv
module rsg_line_timer #(
   parameter int unsigned HW          = 10,
   parameter bit          INTERLACE_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          tick,
   input  logic [HW-1:0] htotal,
   input  logic          interlace,
   output logic          line_done
);
   logic [HW-1:0] hpos;
   logic [HW:0]   step;
   logic [HW:0]   sum;

   generate
      if (INTERLACE_EN) begin : g_step_var
         assign step = interlace ? (HW+1)'(2) : (HW+1)'(1);
      end else begin : g_step_one
         assign step = (HW+1)'(1);
      end
   endgenerate

   assign sum       = {1'b0, hpos} + step;
   assign line_done = tick && (sum > {1'b0, htotal});

   always_ff @(posedge clk) begin
      if (rst || line_done) hpos <= '0;
      else if (tick)        hpos <= sum[HW-1:0];
   end
endmodule

// File: rtl/rsg_frame_ctr.sv
module rsg_frame_ctr #(
   parameter int unsigned VW          = 10,
   parameter bit          INTERLACE_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          line_done,
   input  logic [VW-1:0] vtotal,
   input  logic [VW-1:0] irq1_line,
   input  logic [VW-1:0] irq2_line,
   input  logic [VW-1:0] blank_on,
   input  logic [VW-1:0] blank_off,
   input  logic          ilace_next,
   output logic [VW-1:0] line,
   output logic          blank,
   output logic          field,
   output logic          irq1,
   output logic          irq2,
   output logic          fstart,
   output logic          wrap
);
   logic [VW-1:0] next_line;

   assign next_line = (line == vtotal) ? '0 : line + 1'b1;
   assign wrap      = line_done && (line == vtotal);

   always_ff @(posedge clk) begin
      if (rst) begin
         line   <= '0;
         blank  <= 1'b0;
         irq1   <= 1'b0;
         irq2   <= 1'b0;
         fstart <= 1'b0;
      end else begin
         irq1   <= line_done && (next_line == irq1_line);
         irq2   <= line_done && (next_line == irq2_line);
         fstart <= wrap;
         if (line_done) begin
            line <= next_line;
            if (next_line == blank_on)       blank <= 1'b1;
            else if (next_line == blank_off) blank <= 1'b0;
         end
      end
   end

   generate
      if (INTERLACE_EN) begin : g_field
         always_ff @(posedge clk) begin
            if (rst)       field <= 1'b0;
            else if (wrap) field <= ilace_next ? ~field : 1'b0;
         end
      end else begin : g_no_field
         assign field = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/raster_sync_gen.sv
module raster_sync_gen #(
   parameter int unsigned HW           = 10,
   parameter int unsigned VW           = 10,
   parameter int unsigned HALF_DIV     = 2,
   parameter bit          INTERLACE_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [HW-1:0] cfg_htotal,
   input  logic [VW-1:0] cfg_vtotal,
   input  logic          cfg_full_rate,
   input  logic          cfg_interlace,
   input  logic [VW-1:0] cfg_irq1_line,
   input  logic [VW-1:0] cfg_irq2_line,
   input  logic [VW-1:0] cfg_blank_on,
   input  logic [VW-1:0] cfg_blank_off,
   output logic [VW+1:0] status,
   output logic          scan_irq1,
   output logic          scan_irq2,
   output logic          frame_start
);
   localparam int unsigned SW = VW + 2;

   generate
      if (HW < 2 || VW < 2) begin : g_bad_width
         $error("raster_sync_gen: HW and VW must be at least 2");
      end
   endgenerate

   logic [HW-1:0] sh_htotal;
   logic [VW-1:0] sh_vtotal, sh_irq1, sh_irq2, sh_bon, sh_boff;
   logic          sh_full, sh_ilace;
   logic          pix_tick, line_done, frame_wrap;
   logic [VW-1:0] line;
   logic          blank, field;

   always_ff @(posedge clk) begin
      if (rst || frame_wrap) begin
         sh_htotal <= cfg_htotal;
         sh_vtotal <= cfg_vtotal;
         sh_full   <= cfg_full_rate;
         sh_ilace  <= INTERLACE_EN ? cfg_interlace : 1'b0;
         sh_irq1   <= cfg_irq1_line;
         sh_irq2   <= cfg_irq2_line;
         sh_bon    <= cfg_blank_on;
         sh_boff   <= cfg_blank_off;
      end
   end

   rsg_pix_tick #(.DIV(HALF_DIV)) u_tick (
      .clk       (clk),
      .rst       (rst),
      .full_rate (sh_full),
      .restart   (frame_wrap),
      .tick      (pix_tick)
   );

   rsg_line_timer #(.HW(HW), .INTERLACE_EN(INTERLACE_EN)) u_line (
      .clk       (clk),
      .rst       (rst),
      .tick      (pix_tick),
      .htotal    (sh_htotal),
      .interlace (sh_ilace),
      .line_done (line_done)
   );

   rsg_frame_ctr #(.VW(VW), .INTERLACE_EN(INTERLACE_EN)) u_frame (
      .clk        (clk),
      .rst        (rst),
      .line_done  (line_done),
      .vtotal     (sh_vtotal),
      .irq1_line  (sh_irq1),
      .irq2_line  (sh_irq2),
      .blank_on   (sh_bon),
      .blank_off  (sh_boff),
      .ilace_next (cfg_interlace),
      .line       (line),
      .blank      (blank),
      .field      (field),
      .irq1       (scan_irq1),
      .irq2       (scan_irq2),
      .fstart     (frame_start),
      .wrap       (frame_wrap)
   );

   assign status = SW'({field, blank, line});
endmodule

// File: rtl/rsg_checker.sv
module rsg_checker #(
   parameter int unsigned VW = 10
) (
   input logic          clk,
   input logic          rst,
   input logic          line_done,
   input logic          sh_ilace,
   input logic [VW-1:0] sh_vtotal,
   input logic [VW+1:0] status,
   input logic          scan_irq1,
   input logic          scan_irq2,
   input logic          frame_start
);
   logic [VW-1:0] line;
   logic          blank, field;
   assign line  = status[VW-1:0];
   assign blank = status[VW];
   assign field = status[VW+1];

   AST_LINE_MOVES_AT_END: assert property (@(posedge clk) disable iff (rst)
      !$stable(line) |-> $past(line_done)); // R3
   AST_LINE_STEP_OR_ZERO: assert property (@(posedge clk) disable iff (rst)
      !$stable(line) |-> (line == $past(line) + 1'b1 || line == '0)); // R3
   AST_IRQ1_AT_LINE_END: assert property (@(posedge clk) disable iff (rst)
      scan_irq1 |-> $past(line_done)); // R4
   AST_IRQ2_AT_LINE_END: assert property (@(posedge clk) disable iff (rst)
      scan_irq2 |-> $past(line_done)); // R5
   AST_BLANK_AT_LINE_END: assert property (@(posedge clk) disable iff (rst)
      !$stable(blank) |-> $past(line_done)); // R6
   AST_FIELD_PROG_ZERO: assert property (@(posedge clk) disable iff (rst)
      !sh_ilace |-> !field); // R7
   AST_FIELD_AT_FRAME: assert property (@(posedge clk) disable iff (rst)
      !$stable(field) |-> frame_start); // R8
   AST_FSTART_LINE_ZERO: assert property (@(posedge clk) disable iff (rst)
      frame_start |-> (line == '0 && $past(line_done))); // R9
endmodule

bind raster_sync_gen rsg_checker #(.VW(VW)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .line_done   (line_done),
   .sh_ilace    (sh_ilace),
   .sh_vtotal   (sh_vtotal),
   .status      (status),
   .scan_irq1   (scan_irq1),
   .scan_irq2   (scan_irq2),
   .frame_start (frame_start)
);

// File: tb/sim_raster_sync_gen.sv
`timescale 1ns/1ps
module sim_raster_sync_gen;
   localparam int HW = 10;
   localparam int VW = 10;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [HW-1:0] cfg_htotal = '0;
   logic [VW-1:0] cfg_vtotal = '0;
   logic          cfg_full_rate = 1'b1;
   logic          cfg_interlace = 1'b0;
   logic [VW-1:0] cfg_irq1_line = '0, cfg_irq2_line = '0;
   logic [VW-1:0] cfg_blank_on = '0, cfg_blank_off = '0;
   logic [VW+1:0] status;
   logic          scan_irq1, scan_irq2, frame_start;

   int errors = 0;
   int checks = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   raster_sync_gen #(.HW(HW), .VW(VW)) u0 (
      .clk(clk), .rst(rst),
      .cfg_htotal(cfg_htotal), .cfg_vtotal(cfg_vtotal),
      .cfg_full_rate(cfg_full_rate), .cfg_interlace(cfg_interlace),
      .cfg_irq1_line(cfg_irq1_line), .cfg_irq2_line(cfg_irq2_line),
      .cfg_blank_on(cfg_blank_on), .cfg_blank_off(cfg_blank_off),
      .status(status), .scan_irq1(scan_irq1), .scan_irq2(scan_irq2),
      .frame_start(frame_start)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles == 150000) begin
         errors++;
         $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   task automatic run(input int h, v, fr, il, i1, i2, bon, boff, frames,
                      input bit recfg, input int h2, v2, fr2, il2, j1, j2, bon2, boff2);
      int c_h, c_v, c_fr, c_il, c_i1, c_i2, c_bon, c_boff;
      int prev, ln, seen, wraps, cnt, exp_len, exp_next;
      bit exp_blank, exp_field;
      cfg_htotal = HW'(h); cfg_vtotal = VW'(v); cfg_full_rate = fr[0]; cfg_interlace = il[0];
      cfg_irq1_line = VW'(i1); cfg_irq2_line = VW'(i2);
      cfg_blank_on = VW'(bon); cfg_blank_off = VW'(boff);
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R11: reset state
      check(status == '0, "R11 status in reset", int'(status), 0);
      check(!scan_irq1 && !scan_irq2 && !frame_start, "R11 pulses in reset",
            int'({scan_irq1, scan_irq2, frame_start}), 0);
      c_h = h; c_v = v; c_fr = fr; c_il = il; c_i1 = i1; c_i2 = i2; c_bon = bon; c_boff = boff;
      prev = 0; seen = 0; wraps = 0; cnt = 0; exp_blank = 0; exp_field = 0;
      exp_len = rsg_pkg::ticks_per_line(c_h, c_il[0]) * (c_fr != 0 ? 1 : 2);
      rst = 1'b0;
      while (wraps < frames) begin
         @(negedge clk);
         cnt++;
         ln = int'(status[VW-1:0]);
         if (ln == prev) begin
            if (scan_irq1 || scan_irq2 || frame_start)
               check(1'b0, seen == 0 ? "R11 pulse before first line end" : "R4 R5 R9 pulse without line change",
                     int'({scan_irq1, scan_irq2, frame_start}), 0);
         end else begin
            exp_next = (prev == c_v) ? 0 : prev + 1;
            check(ln == exp_next, "R3 scanline sequence", ln, exp_next);
            if (seen >= 1)
               check(cnt == exp_len, recfg ? "R1 R2 R10 line length" : "R1 R2 line length", cnt, exp_len);
            check(scan_irq1 == (ln == c_i1), "R4 scan_irq1", int'(scan_irq1), int'(ln == c_i1));
            check(scan_irq2 == (ln == c_i2), "R5 scan_irq2", int'(scan_irq2), int'(ln == c_i2));
            check(frame_start == (ln == 0), "R9 frame_start", int'(frame_start), int'(ln == 0));
            if (ln == c_bon)       exp_blank = 1'b1;
            else if (ln == c_boff) exp_blank = 1'b0;
            check(status[VW] == exp_blank, "R6 blanking flag", int'(status[VW]), int'(exp_blank));
            if (ln == 0) begin
               exp_field = cfg_interlace ? ~exp_field : 1'b0;
               c_h = int'(cfg_htotal); c_v = int'(cfg_vtotal); c_fr = int'(cfg_full_rate);
               c_il = int'(cfg_interlace); c_i1 = int'(cfg_irq1_line); c_i2 = int'(cfg_irq2_line);
               c_bon = int'(cfg_blank_on); c_boff = int'(cfg_blank_off);
               wraps++;
            end
            check(status[VW+1] == exp_field, c_il != 0 ? "R8 field toggle" : "R7 field zero",
                  int'(status[VW+1]), int'(exp_field));
            exp_len = rsg_pkg::ticks_per_line(c_h, c_il[0]) * (c_fr != 0 ? 1 : 2);
            seen++;
            cnt = 0;
            prev = ln;
            if (recfg && seen == 2) begin
               // R10: mid-frame rewrite, must wait for the wrap
               cfg_htotal = HW'(h2); cfg_vtotal = VW'(v2); cfg_full_rate = fr2[0];
               cfg_interlace = il2[0]; cfg_irq1_line = VW'(j1); cfg_irq2_line = VW'(j2);
               cfg_blank_on = VW'(bon2); cfg_blank_off = VW'(boff2);
            end
         end
      end
   endtask

   initial begin
      // progressive, full rate, odd and even totals, matches at 0/last/mid
      run(5, 6, 1, 0, 0, 6, 2, 5, 3, 0, 0,0,0,0,0,0,0,0);
      run(4, 5, 1, 0, 3, 3, 5, 0, 3, 0, 0,0,0,0,0,0,0,0);
      // half rate progressive
      run(4, 5, 0, 0, 1, 5, 4, 1, 3, 0, 0,0,0,0,0,0,0,0);
      run(7, 3, 0, 0, 2, 0, 0, 2, 3, 0, 0,0,0,0,0,0,0,0);
      // interlaced: odd and even totals, both rates; equal blank lines (set wins)
      run(7, 4, 1, 1, 4, 1, 3, 3, 4, 0, 0,0,0,0,0,0,0,0);
      run(6, 3, 1, 1, 0, 2, 1, 3, 4, 0, 0,0,0,0,0,0,0,0);
      run(9, 5, 0, 1, 5, 0, 5, 2, 4, 0, 0,0,0,0,0,0,0,0);
      run(0, 2, 1, 0, 1, 2, 0, 1, 3, 0, 0,0,0,0,0,0,0,0);
      // R10: mid-frame reconfiguration in both directions
      run(5, 6, 1, 0, 2, 4, 1, 3, 3, 1, 8, 3, 0, 1, 1, 3, 2, 0);
      run(8, 3, 0, 1, 1, 2, 2, 0, 3, 1, 3, 7, 1, 0, 6, 0, 5, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule